// File: doc/BRIEF.md
# Multi-Channel Reloading Down-Counter Timer

This block holds a bank of down-counting timer channels that share one packed control word. Software writes a per-channel count buffer, loads it into the live counter with a manual-update bit, and starts or stops counting with a start bit. Each counter steps down by one on every cycle where its own count-enable tick input is high. When a ticked counter is already at zero, the channel raises a one-cycle expiry pulse for the interrupt logic. It then either reloads from its buffer and keeps running, or stops and clears its own start bit in the control word.

Every channel except the last also has a compare buffer. A channel's PWM output is high while the live count is above the compare value, and an invert bit can flip it. The last channel has neither a compare buffer nor an invert bit. Its output is high while its count is non-zero. The live count of any channel can be read back through an observation address. Clock prescaling is outside this block: the tick inputs are expected to come already divided.

Top module: `tmr_bank`

## Requirements
- R1: After reset the control word, every count buffer, every compare buffer and every live count read as zero, and all expiry and PWM outputs are low.
- R2: Control bit layout: channel 0 uses bits 3:0 and channel c≥1 uses bits starting at 4c+4. Within a channel the bits are start (+0), manual update (+1), invert (+2) and auto-reload (+3). The last channel has no invert bit and keeps its auto-reload bit at +2, which is bit 22 with five channels.
- R3: A control write that takes a channel's manual-update bit from 0 to 1 copies that channel's count buffer into its live counter at the same clock edge. A write that leaves the bit at 1 does not reload.
- R4: A channel counts only while its start bit is 1. Writing the start bit to 0 freezes the live count, even if ticks keep arriving.
- R5: A running channel whose count is non-zero decrements by exactly one on each cycle its tick input is high, and holds its count on cycles where the tick is low.
- R6: A tick that arrives while a running channel's count is zero makes the channel's expiry output high for the next cycle. If auto-reload is set, the count becomes the buffer value and the start bit stays 1.
- R7: If auto-reload is clear at that terminal tick, hardware clears the channel's start bit and the count stays at zero. No further expiry follows.
- R8: Writing a count buffer while the channel runs leaves the live count unchanged until the next reload or manual update.
- R9: Address map: 0 is the control word. Channel c uses 1+3c for its count buffer, 2+3c for its compare buffer and 3+3c for its read-only live count. Reads are combinational.
- R10: For channels with a compare buffer, the PWM output is (count > compare) XOR invert. The last channel's output is (count ≠ 0). Writes to its compare address are ignored, and that address reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | DATA_W | Combinational read data |
| tick | input | NUM_CH | Per-channel count-enable |
| expire | output | NUM_CH | Per-channel one-cycle expiry pulse |
| pwm_out | output | NUM_CH | Per-channel PWM level |

## Verification
The bench builds the block with five channels, 32-bit data and an 8-bit counter. With five channels the irregular control layout is fully present: the gap after channel 0, the shifted bases and the last channel's missing invert bit with its auto-reload at bit 22. Small buffer values make reload, one-shot stop and terminal expiry reachable within a few ticks. The narrow counter keeps every count and compare value readable as a plain byte.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   // first control bit of a channel
   function automatic int unsigned ctl_base(input int unsigned ch);
      return (ch == 0) ? 0 : 4 * ch + 4;
   endfunction

   function automatic int unsigned ctl_start(input int unsigned ch);
      return ctl_base(ch);
   endfunction

   function automatic int unsigned ctl_manual(input int unsigned ch);
      return ctl_base(ch) + 1;
   endfunction

   function automatic int unsigned ctl_invert(input int unsigned ch);
      return ctl_base(ch) + 2;
   endfunction

   // the last channel lacks the invert bit, so its reload bit moves down
   function automatic int unsigned ctl_reload(input int unsigned ch, input int unsigned nch);
      return (ch == nch - 1) ? ctl_base(ch) + 2 : ctl_base(ch) + 3;
   endfunction

   function automatic int unsigned ctl_width(input int unsigned nch);
      return ctl_base(nch - 1) + 3;
   endfunction

   function automatic int unsigned addr_width(input int unsigned nch);
      return $clog2(3 * nch + 1);
   endfunction

endpackage

// File: rtl/tmr_ctrl_reg.sv
module tmr_ctrl_reg
   import tmr_pkg::*;
#(
   parameter int unsigned NUM_CH = 5,
   localparam int unsigned CTRL_W = ctl_width(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctrl,
   input  logic [CTRL_W-1:0] wr_data,
   input  logic [NUM_CH-1:0] hit,
   output logic [CTRL_W-1:0] ctrl_q,
   output logic [NUM_CH-1:0] run,
   output logic [NUM_CH-1:0] load,
   output logic [NUM_CH-1:0] inv,
   output logic [NUM_CH-1:0] reload
);

   logic [NUM_CH:0][CTRL_W-1:0] clr_acc;
   logic [CTRL_W-1:0]           ctrl_d;

   assign clr_acc[0] = '0;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      localparam int unsigned PS = ctl_start(c);
      localparam int unsigned PM = ctl_manual(c);
      localparam int unsigned PR = ctl_reload(c, NUM_CH);

      assign run[c]    = ctrl_q[PS];
      assign reload[c] = ctrl_q[PR];
      // rising edge of the manual-update bit
      assign load[c]   = wr_ctrl & wr_data[PM] & ~ctrl_q[PM];

      if (c == NUM_CH - 1) begin : g_noinv
         assign inv[c] = 1'b0;
      end else begin : g_inv
         localparam int unsigned PI = ctl_invert(c);
         assign inv[c] = ctrl_q[PI];
      end

      assign clr_acc[c+1] = clr_acc[c]
                          | (CTRL_W'(hit[c] & ~reload[c]) << PS);

      // R7
      oneshot_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!wr_ctrl && hit[c] && !reload[c]) |=> !run[c]);
   end

   // a software write takes precedence over the hardware start clear
   always_comb begin
      if (wr_ctrl) ctrl_d = wr_data;
      else         ctrl_d = ctrl_q & ~clr_acc[NUM_CH];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_q <= '0;
      else        ctrl_q <= ctrl_d;
   end

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan #(
   parameter int unsigned CNT_W   = 16,
   parameter bit          HAS_CMP = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_cnt,
   input  logic             wr_cmp,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             tick,
   input  logic             run,
   input  logic             load,
   input  logic             reload,
   input  logic             inv,
   output logic             hit,
   output logic             expire,
   output logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] buf_val,
   output logic [CNT_W-1:0] cmp_val,
   output logic             pwm
);

   logic [CNT_W-1:0] count_q, buf_q;
   logic             expire_q, at_zero;

   assign at_zero = (count_q == '0);
   // terminal tick; a manual update in the same cycle wins
   assign hit     = run & tick & at_zero & ~load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q  <= '0;
         buf_q    <= '0;
         expire_q <= 1'b0;
      end else begin
         if (wr_cnt) buf_q <= wr_data;
         expire_q <= hit;
         if (load)             count_q <= buf_q;
         else if (hit)         count_q <= reload ? buf_q : '0;
         else if (run && tick) count_q <= count_q - 1'b1;
      end
   end

   assign count   = count_q;
   assign buf_val = buf_q;
   assign expire  = expire_q;

   if (HAS_CMP) begin : g_cmp
      logic [CNT_W-1:0] cmp_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      cmp_q <= '0;
         else if (wr_cmp) cmp_q <= wr_data;
      end
      assign cmp_val = cmp_q;
      assign pwm     = (count_q > cmp_q) ^ inv;
   end else begin : g_nocmp
      logic unused_cmp_in;
      assign unused_cmp_in = wr_cmp ^ inv;
      assign cmp_val       = '0;
      assign pwm           = ~at_zero;
   end

   // R5
   tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && !load && !at_zero) |=> (count_q == $past(count_q) - 1'b1));

   // R4
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !load) |=> $stable(count_q));

   // R6
   reload_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && reload) |=> (expire && count_q == $past(buf_q)));

endmodule

// File: rtl/tmr_rd_mux.sv
module tmr_rd_mux #(
   parameter int unsigned NUM_CH = 5,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CTRL_W = 23,
   parameter int unsigned ADDR_W = 4
) (
   input  logic [ADDR_W-1:0]             rd_addr,
   input  logic [CTRL_W-1:0]             ctrl,
   input  logic [NUM_CH-1:0][CNT_W-1:0]  bufs,
   input  logic [NUM_CH-1:0][CNT_W-1:0]  cmps,
   input  logic [NUM_CH-1:0][CNT_W-1:0]  cnts,
   output logic [DATA_W-1:0]             rd_data
);

   logic [NUM_CH:0][DATA_W-1:0] acc;

   assign acc[0] = (rd_addr == '0) ? DATA_W'(ctrl) : '0;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      localparam logic [ADDR_W-1:0] A_BUF = ADDR_W'(1 + 3 * c);
      localparam logic [ADDR_W-1:0] A_CMP = ADDR_W'(2 + 3 * c);
      localparam logic [ADDR_W-1:0] A_OBS = ADDR_W'(3 + 3 * c);
      logic [DATA_W-1:0] part;
      always_comb begin
         unique case (rd_addr)
            A_BUF:   part = DATA_W'(bufs[c]);
            A_CMP:   part = DATA_W'(cmps[c]);
            A_OBS:   part = DATA_W'(cnts[c]);
            default: part = '0;
         endcase
      end
      assign acc[c+1] = acc[c] | part;
   end

   assign rd_data = acc[NUM_CH];

endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
   import tmr_pkg::*;
#(
   parameter int unsigned NUM_CH = 5,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned DATA_W = 32,
   localparam int unsigned CTRL_W = ctl_width(NUM_CH),
   localparam int unsigned ADDR_W = addr_width(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic [NUM_CH-1:0] tick,
   output logic [NUM_CH-1:0] expire,
   output logic [NUM_CH-1:0] pwm_out
);

   if (NUM_CH < 2 || CTRL_W > DATA_W) begin : g_bad_ch
      $error("tmr_bank: NUM_CH must be at least 2 and its control word must fit DATA_W");
   end
   if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("tmr_bank: CNT_W must lie between 2 and DATA_W");
   end

   logic [CTRL_W-1:0]            ctrl_q;
   logic [NUM_CH-1:0]            run, load, inv, reload, hit;
   logic [NUM_CH-1:0][CNT_W-1:0] cnt_v, buf_v, cmp_v;
   logic                         wr_ctrl;
   logic                         unused_wdata;

   assign wr_ctrl      = wr_en && (wr_addr == '0);
   assign unused_wdata = ^wr_data;

   tmr_ctrl_reg #(.NUM_CH(NUM_CH)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_ctrl (wr_ctrl),
      .wr_data (wr_data[CTRL_W-1:0]),
      .hit     (hit),
      .ctrl_q  (ctrl_q),
      .run     (run),
      .load    (load),
      .inv     (inv),
      .reload  (reload)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      localparam logic [ADDR_W-1:0] A_BUF = ADDR_W'(1 + 3 * c);
      localparam logic [ADDR_W-1:0] A_CMP = ADDR_W'(2 + 3 * c);
      logic wr_buf, wr_cmp;
      assign wr_buf = wr_en && (wr_addr == A_BUF);
      assign wr_cmp = wr_en && (wr_addr == A_CMP);

      tmr_chan #(
         .CNT_W   (CNT_W),
         .HAS_CMP (c != NUM_CH - 1)
      ) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_cnt  (wr_buf),
         .wr_cmp  (wr_cmp),
         .wr_data (wr_data[CNT_W-1:0]),
         .tick    (tick[c]),
         .run     (run[c]),
         .load    (load[c]),
         .reload  (reload[c]),
         .inv     (inv[c]),
         .hit     (hit[c]),
         .expire  (expire[c]),
         .count   (cnt_v[c]),
         .buf_val (buf_v[c]),
         .cmp_val (cmp_v[c]),
         .pwm     (pwm_out[c])
      );
   end

   tmr_rd_mux #(
      .NUM_CH (NUM_CH),
      .CNT_W  (CNT_W),
      .DATA_W (DATA_W),
      .CTRL_W (CTRL_W),
      .ADDR_W (ADDR_W)
   ) u_rd (
      .rd_addr (rd_addr),
      .ctrl    (ctrl_q),
      .bufs    (buf_v),
      .cmps    (cmp_v),
      .cnts    (cnt_v),
      .rd_data (rd_data)
   );

endmodule

// File: tb/tb_tmr_bank.sv
module tb_tmr_bank;

   localparam int unsigned NCH = 5;
   localparam int unsigned AW  = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            wr_en = 1'b0;
   logic [AW-1:0]   wr_addr = '0;
   logic [31:0]     wr_data = '0;
   logic [AW-1:0]   rd_addr = '0;
   logic [31:0]     rd_data;
   logic [NCH-1:0]  tk = '0;
   logic [NCH-1:0]  expire;
   logic [NCH-1:0]  pwm_out;

   int total = 0;
   int bad   = 0;

   tmr_bank #(.NUM_CH(NCH), .CNT_W(8), .DATA_W(32)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .tick(tk), .expire(expire), .pwm_out(pwm_out)
   );

   always #5 clk = ~clk;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // all tasks start and end just after a falling edge
   task automatic wr(input int a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      rd_addr = AW'(a);
      #1 d = rd_data;
   endtask

   task automatic pulse(input int c);
      tk = '0; tk[c] = 1'b1;
      @(negedge clk);
      tk = '0;
   endtask

   function automatic int obs(input int c); return 3 + 3 * c; endfunction

   task automatic t_reset;
      logic [31:0] v;
      rd(0, v);      chk("R1 control word", v, 0);
      rd(1, v);      chk("R1 count buffer ch0", v, 0);
      rd(11, v);     chk("R1 compare buffer ch3", v, 0);
      rd(obs(3), v); chk("R1 live count ch3", v, 0);
      chk("R1 expiry", 32'(expire), 0);
      chk("R1 pwm", 32'(pwm_out), 0);
   endtask

   task automatic t_manual;
      logic [31:0] v;
      wr(4, 10);
      wr(0, 32'h200);                 // ch1 manual bit 9
      rd(obs(1), v); chk("R3 manual update ch1", v, 10);
      wr(4, 20);
      wr(0, 32'h200);                 // bit already set
      rd(obs(1), v); chk("R3 no reload without edge", v, 10);
      wr(0, 0);
      wr(0, 32'h200);
      rd(obs(1), v); chk("R3 reload on new edge", v, 20);
   endtask

   task automatic t_count;
      logic [31:0] v;
      wr(0, 32'h100);                 // ch1 start bit 8
      repeat (3) @(negedge clk);
      rd(obs(1), v); chk("R5 hold without tick", v, 20);
      repeat (5) pulse(1);
      rd(obs(1), v); chk("R5 five ticks", v, 15);
      wr(4, 3);
      rd(obs(1), v); chk("R8 buffer write while running", v, 15);
      pulse(1);
      rd(obs(1), v); chk("R8 count continues from live value", v, 14);
      wr(0, 0);
      repeat (2) pulse(1);
      rd(obs(1), v); chk("R4 stopped channel holds", v, 14);
   endtask

   task automatic t_autoreload;
      logic [31:0] v;
      wr(1, 2);
      wr(0, 32'h2);                   // ch0 manual bit 1
      wr(0, 32'h9);                   // start bit 0, reload bit 3
      pulse(0);
      chk("R6 no expiry mid count", 32'(expire), 0);
      pulse(0);
      rd(obs(0), v); chk("R6 reaches zero", v, 0);
      chk("R6 no expiry on reaching zero", 32'(expire), 0);
      pulse(0);
      chk("R6 expiry pulse ch0", 32'(expire), 32'h1);
      rd(obs(0), v); chk("R6 reload from buffer", v, 2);
      rd(0, v);      chk("R6 start stays set", v & 32'h1, 1);
      pulse(0);
      chk("R6 expiry lasts one cycle", 32'(expire), 0);
      rd(obs(0), v); chk("R6 keeps counting", v, 1);
   endtask

   task automatic t_oneshot;
      logic [31:0] v;
      wr(0, 0);
      wr(13, 1);
      wr(0, 32'h20_0000);             // ch4 manual bit 21
      rd(obs(4), v); chk("R2 ch4 manual bit 21", v, 1);
      wr(0, 32'h10_0000);             // ch4 start bit 20, reload clear
      pulse(4);
      pulse(4);
      chk("R7 expiry ch4", 32'(expire), 32'h10);
      rd(0, v);      chk("R7 start bit cleared", v, 0);
      rd(obs(4), v); chk("R7 count stays zero", v, 0);
      pulse(4);
      chk("R7 no further expiry", 32'(expire), 0);
      wr(0, 32'h20_0000);             // load 1 again
      wr(0, 32'h50_0000);             // start 20 + reload 22
      pulse(4);
      pulse(4);
      chk("R2 ch4 reload bit 22 expiry", 32'(expire), 32'h10);
      rd(obs(4), v); chk("R2 ch4 reloaded", v, 1);
      rd(0, v);      chk("R2 ch4 start kept", v, 32'h50_0000);
   endtask

   task automatic t_pwm;
      logic [31:0] v;
      wr(0, 0);
      wr(7, 5);
      wr(8, 3);
      wr(0, 32'h2000);                // ch2 manual bit 13
      chk("R10 count above compare", 32'(pwm_out[2]), 1);
      rd(8, v);      chk("R9 compare readback ch2", v, 3);
      rd(7, v);      chk("R9 buffer readback ch2", v, 5);
      wr(8, 5);
      chk("R10 count equal compare", 32'(pwm_out[2]), 0);
      wr(0, 32'h6000);                // keep manual, set invert bit 14
      rd(obs(2), v); chk("R3 no reload when only invert changes", v, 5);
      chk("R10 inverted", 32'(pwm_out[2]), 1);
      wr(14, 7);
      rd(14, v);     chk("R10 ch4 compare ignored", v, 0);
      chk("R10 ch4 high when nonzero", 32'(pwm_out[4]), 1);
      wr(13, 0);
      wr(0, 32'h20_0000);
      chk("R10 ch4 low at zero", 32'(pwm_out[4]), 0);
      rd(15, v);     chk("R9 ch4 observe", v, 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_manual();
      t_count();
      t_autoreload();
      t_oneshot();
      t_pwm();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule